// File: doc/BRIEF.md
# Edge-Ordered Three-State Phase Comparator

This block compares a reference input with a feedback input and produces a three-level correction: push up, push down, or release the line to high impedance. Inside is a three-position saturating state machine. A rising edge on the reference moves it one position up and a rising edge on the feedback moves it one position down. Only the order of rising edges matters. Level overlap and duty cycle have no effect. The neutral middle position is the released, or locked, condition. Because the machine has memory, two inputs at the same frequency with alternating edges stay wherever they started. They settle in the neutral position only if the machine was already there.

Both inputs are asynchronous to the system clock. Each one passes through a synchronizer chain and a rising-edge detector before it reaches the state machine. Each input level must therefore last at least two clock periods high and two clock periods low. The block drives a tri-state pin together with an equivalent enable/value pair. It also gives an alignment flag that is high only in the neutral position, and separate up and down flags. There is no stream interface and no back-pressure: every pin is a plain control or status level.

Top module: `pfd_tristate_cmp`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the neutral position: `up_o`=0, `dn_o`=0, `aligned_o`=1, `drive_en_o`=0. This holds in the cycle after any clock edge at which `rst` is high.
- R2: Each detected reference rising edge with no feedback edge in the same cycle steps the position up one step: down to neutral, or neutral to up.
- R3: Each detected feedback rising edge with no reference edge in the same cycle steps the position down one step: up to neutral, or neutral to down.
- R4: Starting from neutral, two reference rising edges with no feedback edge between them leave the block in up. Two feedback rising edges with no reference edge between them leave it in down.
- R5: The position saturates. A reference edge while up leaves it up, and a feedback edge while down leaves it down.
- R6: Rising edges on both inputs detected in the same clock cycle leave the position unchanged.
- R7: Only rising edges have an effect. Input high time, falling edges and level overlap do not change the position. From the up position, a feedback edge followed by a reference edge returns to up. From neutral, a reference edge followed by a feedback edge returns to neutral.
- R8: `aligned_o` is 1 exactly when the block is in neutral, that is when neither `up_o` nor `dn_o` is set.
- R9: The pin encoding is as follows. `drive_en_o` = 1 in up or down. `drive_val_o` = 1 in up and 0 in down. `pump_o` carries `drive_val_o` while `drive_en_o` is 1 and is high impedance otherwise.
- R10: Take an input held low and then made high before clock edge n, with edge n being the first edge to sample the high level. The resulting position change is visible after edge n+2 and not before.
- R11: `up_o` and `dn_o` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous active-high reset to neutral |
| ref_i | input | 1 | Reference input, asynchronous |
| fb_i | input | 1 | Feedback input, asynchronous |
| up_o | output | 1 | Up position active (pin driven high) |
| dn_o | output | 1 | Down position active (pin driven low) |
| aligned_o | output | 1 | High in the neutral position |
| drive_en_o | output | 1 | Pin drive enable |
| drive_val_o | output | 1 | Pin drive value when enabled |
| pump_o | output | 1 | Tri-state correction pin |

## Verification
The directed patterns are as follows:
- Single pulses on one input separate the one-step moves from any multi-step jump.
- Repeated pulses on the same input show saturation at each end.
- Pulses on both inputs in the same cycle show cancellation.
- A long reference high time, started from the down position, tells edge sensitivity apart from level sensitivity. A level-driven design would reach up, while the correct result is neutral.
- Closely spaced feedback-then-reference pairs started from up and from neutral show that the final position depends on the starting position.
- Counting sample edges around a single rising level pins down the synchronizer latency.

A random stretch of legal-width pulses is then compared every clock against a queue-based behavioural model.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    POS_DOWN = 2'b00,
    POS_MID  = 2'b01,
    POS_UP   = 2'b10
  } pfd_pos_e;
endpackage

// File: rtl/pfd_sync_edge.sv
module pfd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic          hist_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) hist_q <= 1'b0;
    else     hist_q <= chain_q[LAST];
  end

  assign rise = chain_q[LAST] & ~hist_q;
endmodule

// File: rtl/pfd_step_core.sv
module pfd_step_core
  import pfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step_up,
  input  logic     step_dn,
  output pfd_pos_e pos
);
  pfd_pos_e pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    unique case ({step_up, step_dn})
      2'b10: pos_d = (pos_q == POS_DOWN) ? POS_MID : POS_UP;
      2'b01: pos_d = (pos_q == POS_UP) ? POS_MID : POS_DOWN;
      default: pos_d = pos_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pos_q <= POS_MID;
    else     pos_q <= pos_d;
  end

  assign pos = pos_q;
endmodule

// File: rtl/pfd_tristate_cmp.sv
module pfd_tristate_cmp
  import pfd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_o,
  output logic dn_o,
  output logic aligned_o,
  output logic drive_en_o,
  output logic drive_val_o,
  output wire  pump_o
);
  logic     ref_rise;
  logic     fb_rise;
  pfd_pos_e pos;

  pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_ref_edge (
    .clk (clk),
    .rst (rst),
    .din (ref_i),
    .rise(ref_rise)
  );

  pfd_sync_edge #(.STAGES(SYNC_STAGES)) u_fb_edge (
    .clk (clk),
    .rst (rst),
    .din (fb_i),
    .rise(fb_rise)
  );

  pfd_step_core u_core (
    .clk    (clk),
    .rst    (rst),
    .step_up(ref_rise),
    .step_dn(fb_rise),
    .pos    (pos)
  );

  assign up_o        = (pos == POS_UP);
  assign dn_o        = (pos == POS_DOWN);
  assign aligned_o   = (pos == POS_MID);
  assign drive_en_o  = (pos != POS_MID);
  assign drive_val_o = (pos == POS_UP);
  assign pump_o      = drive_en_o ? drive_val_o : 1'bz;
endmodule

// File: rtl/pfd_tristate_cmp_chk.sv
module pfd_tristate_cmp_chk (
  input logic clk,
  input logic rst,
  input logic ref_rise,
  input logic fb_rise,
  input logic up_o,
  input logic dn_o,
  input logic aligned_o,
  input logic drive_en_o,
  input logic drive_val_o
);
  AST_RESET_NEUTRAL: assert property (@(posedge clk) rst |=> (aligned_o && !up_o && !dn_o)); // R1
  AST_UP_FROM_DOWN: assert property (@(posedge clk) disable iff (rst) dn_o |=> !up_o); // R2
  AST_DOWN_FROM_UP: assert property (@(posedge clk) disable iff (rst) up_o |=> !dn_o); // R3
  AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst) (up_o && ref_rise && !fb_rise) |=> up_o); // R5
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (rst) (dn_o && fb_rise && !ref_rise) |=> dn_o); // R5
  AST_CANCEL_BOTH: assert property (@(posedge clk) disable iff (rst) (ref_rise && fb_rise) |=> $stable({up_o, dn_o})); // R6
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (rst) (!ref_rise && !fb_rise) |=> $stable({up_o, dn_o})); // R7
  AST_ALIGNED_NEUTRAL: assert property (@(posedge clk) disable iff (rst) aligned_o == !(up_o || dn_o)); // R8
  AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (rst) drive_en_o == (up_o || dn_o)); // R9
  AST_PIN_VALUE: assert property (@(posedge clk) disable iff (rst) drive_en_o |-> (drive_val_o == up_o)); // R9
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst) !(up_o && dn_o)); // R11
endmodule

bind pfd_tristate_cmp pfd_tristate_cmp_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .ref_rise   (ref_rise),
  .fb_rise    (fb_rise),
  .up_o       (up_o),
  .dn_o       (dn_o),
  .aligned_o  (aligned_o),
  .drive_en_o (drive_en_o),
  .drive_val_o(drive_val_o)
);

// File: tb/pfd_tristate_cmp_tb.sv
module pfd_tristate_cmp_tb;
  localparam int CLK_PERIOD = 10;
  localparam int STG = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_i = 1'b0;
  logic fb_i = 1'b0;
  logic up_o, dn_o, aligned_o, drive_en_o, drive_val_o;
  wire  pump_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  int href[$];
  int hfb[$];
  int mpos = 1;  // 0 down, 1 neutral, 2 up

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_tristate_cmp #(.SYNC_STAGES(STG)) u_dut (
    .clk(clk), .rst(rst), .ref_i(ref_i), .fb_i(fb_i),
    .up_o(up_o), .dn_o(dn_o), .aligned_o(aligned_o),
    .drive_en_o(drive_en_o), .drive_val_o(drive_val_o), .pump_o(pump_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural model: history queues of sampled levels
  initial begin
    for (int i = 0; i < STG + 2; i++) begin
      href.push_back(0);
      hfb.push_back(0);
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      href.push_back(0);
      hfb.push_back(0);
      mpos = 1;
    end else begin
      int n;
      bit ru, rd;
      href.push_back(int'(ref_i));
      hfb.push_back(int'(fb_i));
      n  = href.size();
      ru = (href[n-1-STG] == 1) && (href[n-2-STG] == 0);
      rd = (hfb[n-1-STG] == 1) && (hfb[n-2-STG] == 0);
      if (ru && !rd && mpos < 2) mpos++;
      else if (rd && !ru && mpos > 0) mpos--;
    end
    if (href.size() > 16) begin
      void'(href.pop_front());
      void'(hfb.pop_front());
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(up_o == (mpos == 2), "R2 model up", int'(up_o), int'(mpos == 2));
      check(dn_o == (mpos == 0), "R3 model down", int'(dn_o), int'(mpos == 0));
      check(aligned_o == (mpos == 1), "R8 model aligned", int'(aligned_o), int'(mpos == 1));
      check(drive_en_o == (mpos != 1), "R9 model enable", int'(drive_en_o), int'(mpos != 1));
      if (mpos != 1)
        check(drive_val_o == (mpos == 2), "R9 model value", int'(drive_val_o), int'(mpos == 2));
      check(!(up_o && dn_o), "R11 exclusive", int'(up_o && dn_o), 0);
    end
  end

  // returns 0 down, 1 neutral, 2 up, 3 illegal
  function automatic int dut_pos();
    if (up_o && !dn_o && !aligned_o) return 2;
    if (dn_o && !up_o && !aligned_o) return 0;
    if (aligned_o && !up_o && !dn_o) return 1;
    return 3;
  endfunction

  task automatic pulse(input bit r, input bit f, input int hi);
    @(negedge clk);
    if (r) ref_i = 1'b1;
    if (f) fb_i = 1'b1;
    repeat (hi) @(negedge clk);
    ref_i = 1'b0;
    fb_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    check(dut_pos() == 1, "R1 reset neutral", dut_pos(), 1);
    check(drive_en_o == 1'b0, "R1 reset pin released", int'(drive_en_o), 0);

    // R10 latency: high sampled first at edge n, visible after n+2
    @(negedge clk);
    ref_i = 1'b1;
    @(negedge clk);  // after edge n
    check(dut_pos() == 1, "R10 unchanged after n", dut_pos(), 1);
    @(negedge clk);  // after n+1
    check(dut_pos() == 1, "R10 unchanged after n+1", dut_pos(), 1);
    @(negedge clk);  // after n+2
    check(dut_pos() == 2, "R10 changed after n+2", dut_pos(), 2);
    ref_i = 1'b0;
    repeat (3) @(negedge clk);
    check(pump_o === 1'b1, "R9 pin high in up", int'(pump_o), 1);

    pulse(1, 0, 2);
    check(dut_pos() == 2, "R5 saturate up", dut_pos(), 2);
    pulse(0, 1, 2);
    check(dut_pos() == 1, "R3 up to neutral", dut_pos(), 1);
    pulse(0, 1, 3);
    check(dut_pos() == 0, "R3 neutral to down", dut_pos(), 0);
    check(pump_o === 1'b0, "R9 pin low in down", int'(pump_o), 0);
    pulse(0, 1, 2);
    check(dut_pos() == 0, "R5 saturate down", dut_pos(), 0);
    pulse(1, 0, 2);
    check(dut_pos() == 1, "R2 down to neutral", dut_pos(), 1);

    // R4 two same-input edges from neutral
    pulse(0, 1, 2);
    pulse(0, 1, 2);
    check(dut_pos() == 0, "R4 two feedback edges", dut_pos(), 0);
    do_reset();
    pulse(1, 0, 2);
    pulse(1, 0, 5);
    check(dut_pos() == 2, "R4 two reference edges", dut_pos(), 2);

    // R6 simultaneous edges cancel
    pulse(1, 1, 3);
    check(dut_pos() == 2, "R6 cancel from up", dut_pos(), 2);
    do_reset();
    pulse(1, 1, 2);
    check(dut_pos() == 1, "R6 cancel from neutral", dut_pos(), 1);

    // R7 feedback then reference from up returns to up
    pulse(1, 0, 2);
    @(negedge clk); fb_i = 1'b1;
    @(negedge clk); ref_i = 1'b1;
    @(negedge clk); fb_i = 1'b0;
    @(negedge clk); ref_i = 1'b0;
    repeat (5) @(negedge clk);
    check(dut_pos() == 2, "R7 alternating from up", dut_pos(), 2);
    do_reset();
    @(negedge clk); ref_i = 1'b1;
    @(negedge clk); fb_i = 1'b1;
    @(negedge clk); ref_i = 1'b0;
    @(negedge clk); fb_i = 1'b0;
    repeat (5) @(negedge clk);
    check(dut_pos() == 1, "R7 alternating from neutral", dut_pos(), 1);

    // R7 long high level from down yields one step only
    pulse(0, 1, 2);
    pulse(1, 0, 30);
    check(dut_pos() == 1, "R7 long level one step", dut_pos(), 1);

    // R1 reset mid-operation
    pulse(1, 0, 2);
    do_reset();
    check(dut_pos() == 1, "R1 reset from up", dut_pos(), 1);

    // random legal-width stimulus against the model
    for (int k = 0; k < 400; k++) begin
      int w;
      @(negedge clk);
      w = 2 + int'($urandom_range(3, 0));
      if ($urandom_range(1, 0) == 1) ref_i = ~ref_i;
      if ($urandom_range(1, 0) == 1) fb_i = ~fb_i;
      repeat (w - 1) @(negedge clk);
    end
    ref_i = 1'b0;
    fb_i = 1'b0;
    repeat (6) @(negedge clk);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule